// File: doc/BRIEF.md
# Programmable Square-Wave Tone Channel

This block produces one square-wave voice for a small sound generator. A 10-bit half-period value sets the pitch. A 4-bit attenuation code sets the loudness in 2 dB steps. The block runs on the system clock and advances only when a clock-enable pulse arrives. That pulse comes from outside at one sixteenth of the reference clock rate.

A down-counter counts enable pulses. When it runs out, it raises a borrow, reloads itself from the period value and flips the output flip-flop. The audible frequency is therefore the reference clock divided by 32 times the period value. The block outputs the raw square bit and a 4-bit linear amplitude, which is zero while the square bit is low. It also outputs a one-cycle borrow strobe that a neighbouring noise source can use as a shift clock.

Top module: `tone_channel`

## Requirements
- R1: While rst_n is low at a clock edge, the next state has tone_o = 0, borrow_o = 0 and level_o = 0, the counter is cleared, and the registered attenuation is set to code 1111 (silent).
- R2: With a tick every 16 clocks and period_i = P (1 to 1023), successive borrow_o pulses are exactly 16·P clocks apart. Borrows are therefore P ticks apart, and one full square period is 2·P ticks.
- R3: tone_o inverts in exactly the cycles where borrow_o is high, and it is stable in every other cycle.
- R4: borrow_o is high for one cycle per borrow. It is high only in the cycle right after a clock edge at which tick_i was high.
- R5: A period_i value of 0 counts as 1024 ticks between borrows (16384 clocks at one tick per 16 clocks).
- R6: period_i is sampled only at the tick that produces a borrow. A new value given during a half-period takes effect from the next reload. A value present at the very edge of the reload is the one taken.
- R7: With tone_o high, level_o follows the registered attenuation code 0..15 through the table 15, 12, 9, 8, 6, 5, 4, 3, 2, 2, 2, 1, 1, 1, 1, 0. Code 0 is loudest and code 15 (all four bits set) is silent.
- R8: level_o is 0 whenever tone_o is low.
- R9: atten_i is registered every clock, so a change on atten_i shows up on level_o one clock later.
- R10: While tick_i stays low, the counter holds its value. No borrow occurs and tone_o does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tick_i | input | 1 | Clock-enable pulse at the reference rate divided by 16 |
| period_i | input | 10 | Half-period in ticks, bit 9 most significant; 0 means 1024 |
| atten_i | input | 4 | Attenuation code, bit weights 2/4/8/16 dB from bit 0; 1111 is off |
| tone_o | output | 1 | Raw square-wave bit |
| level_o | output | 4 | Attenuated linear amplitude, zero while tone_o is low |
| borrow_o | output | 1 | One-cycle strobe on each counter borrow |

## Verification
Two functions can act at the same clock edge: the reload caused by a borrow, and a change of the period value. The bench predicts the cycle of the next borrow from the previous borrow stamp. It then changes period_i on the falling edge just before that reload edge. The check passes only if the new value sets the very next interval, and that interval is measured exactly in clocks. In a second case the period is changed right after a borrow. There the old interval must finish unchanged before the new one starts.

// File: rtl/tone_pkg.sv
// Package: shared widths and the attenuation-to-level table of the tone channel.
// Assumes a 4-bit attenuation code and a 4-bit linear output level.
package tone_pkg;
    localparam int PERIOD_W = 10;
    localparam int ATTEN_W  = 4;
    localparam int LEVEL_W  = 4;

    typedef logic [ATTEN_W-1:0] atten_t;
    typedef logic [LEVEL_W-1:0] level_t;

    // Code 15 (all bits set) is silence.
    localparam atten_t ATTEN_OFF = '1;

    // Linear amplitude for each 2 dB step of attenuation, rounded from 15*10^(-k/10).
    function automatic level_t atten_to_level(input atten_t code);
        level_t lvl;
        case (code)
            4'd0:  lvl = 4'd15;
            4'd1:  lvl = 4'd12;
            4'd2:  lvl = 4'd9;
            4'd3:  lvl = 4'd8;
            4'd4:  lvl = 4'd6;
            4'd5:  lvl = 4'd5;
            4'd6:  lvl = 4'd4;
            4'd7:  lvl = 4'd3;
            4'd8:  lvl = 4'd2;
            4'd9:  lvl = 4'd2;
            4'd10: lvl = 4'd2;
            4'd11: lvl = 4'd1;
            4'd12: lvl = 4'd1;
            4'd13: lvl = 4'd1;
            4'd14: lvl = 4'd1;
            default: lvl = 4'd0;
        endcase
        return lvl;
    endfunction
endpackage

// File: rtl/tone_divider.sv
// Module: half-period down-counter.
// Counts tick_i pulses. At a tick with the count at zero it signals a borrow
// and reloads with period_i - 1, so borrows are period_i ticks apart
// (0 wraps to 1023, giving 1024 ticks). Assumes period_i is valid at each tick.
module tone_divider #(
    parameter int PERIOD_W = tone_pkg::PERIOD_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                tick_i,
    input  logic [PERIOD_W-1:0] period_i,
    output logic                borrow_o
);
    logic [PERIOD_W-1:0] cnt_q;
    logic                at_zero;

    // Purpose: detect the terminal count.
    assign at_zero  = (cnt_q == '0);
    // Purpose: a borrow is a tick that finds the counter empty.
    assign borrow_o = tick_i && at_zero;

    // Purpose: decrement on each tick, reload from the period on borrow.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (tick_i) begin
            if (at_zero) begin
                cnt_q <= period_i - 1'b1;
            end else begin
                cnt_q <= cnt_q - 1'b1;
            end
        end
    end
endmodule

// File: rtl/tone_flipflop.sv
// Module: output flip-flop and borrow strobe register.
// Inverts the square bit on each borrow and registers a one-cycle strobe
// aligned with the new square value. Assumes borrow_i is a combinational pulse.
module tone_flipflop (
    input  logic clk,
    input  logic rst_n,
    input  logic borrow_i,
    output logic tone_o,
    output logic strobe_o
);
    logic tone_q;
    logic strobe_q;

    // Purpose: invert the square bit and raise the strobe for each borrow.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tone_q   <= 1'b0;
            strobe_q <= 1'b0;
        end else begin
            strobe_q <= borrow_i;
            if (borrow_i) begin
                tone_q <= ~tone_q;
            end
        end
    end

    assign tone_o   = tone_q;
    assign strobe_o = strobe_q;
endmodule

// File: rtl/tone_level.sv
// Module: attenuation register and amplitude mapping.
// Registers the attenuation code every clock (silent after reset), maps it to
// a linear level and gates it with the square bit.
module tone_level #(
    parameter int ATTEN_W = tone_pkg::ATTEN_W,
    parameter int LEVEL_W = tone_pkg::LEVEL_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ATTEN_W-1:0] atten_i,
    input  logic               tone_i,
    output logic [LEVEL_W-1:0] level_o
);
    import tone_pkg::*;

    localparam int NUM_CODES = 1 << ATTEN_W;

    logic [ATTEN_W-1:0] atten_q;
    logic [LEVEL_W-1:0] table_lvl;

    // Purpose: hold the attenuation code, forced to silence by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            atten_q <= {ATTEN_W{1'b1}};
        end else begin
            atten_q <= atten_i;
        end
    end

    // Purpose: pick the table, or a plain linear fall-off for other widths.
    generate
        if (ATTEN_W == 4 && LEVEL_W == 4) begin : g_db_table
            assign table_lvl = atten_to_level(atten_q);
        end else begin : g_linear
            assign table_lvl = LEVEL_W'(((NUM_CODES - 1) - int'(atten_q))
                               * ((1 << LEVEL_W) - 1) / (NUM_CODES - 1));
        end
    endgenerate

    // Purpose: silence the output while the square bit is low.
    assign level_o = tone_i ? table_lvl : '0;
endmodule

// File: rtl/tone_channel.sv
// Module: one programmable square-wave tone channel (top).
// Chains the half-period counter, the output flip-flop and the level mapping.
// Assumes tick_i is a single-cycle enable at the reference clock divided by 16.
module tone_channel #(
    parameter int PERIOD_W = tone_pkg::PERIOD_W,
    parameter int ATTEN_W  = tone_pkg::ATTEN_W,
    parameter int LEVEL_W  = tone_pkg::LEVEL_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                tick_i,
    input  logic [PERIOD_W-1:0] period_i,
    input  logic [ATTEN_W-1:0]  atten_i,
    output logic                tone_o,
    output logic [LEVEL_W-1:0]  level_o,
    output logic                borrow_o
);
    logic borrow_now;
    logic tone_sq;

    // Purpose: count ticks and flag each borrow.
    tone_divider #(.PERIOD_W(PERIOD_W)) u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick_i   (tick_i),
        .period_i (period_i),
        .borrow_o (borrow_now)
    );

    // Purpose: flip the square bit and register the strobe.
    tone_flipflop u_ff (
        .clk      (clk),
        .rst_n    (rst_n),
        .borrow_i (borrow_now),
        .tone_o   (tone_sq),
        .strobe_o (borrow_o)
    );

    // Purpose: turn the attenuation code into the gated amplitude.
    tone_level #(.ATTEN_W(ATTEN_W), .LEVEL_W(LEVEL_W)) u_lvl (
        .clk     (clk),
        .rst_n   (rst_n),
        .atten_i (atten_i),
        .tone_i  (tone_sq),
        .level_o (level_o)
    );

    assign tone_o = tone_sq;
endmodule

// File: rtl/tone_channel_chk.sv
// Module: protocol checker for tone_channel, attached through bind.
module tone_channel_chk #(
    parameter int ATTEN_W = 4,
    parameter int LEVEL_W = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic               tick_i,
    input logic [ATTEN_W-1:0] atten_i,
    input logic               tone_o,
    input logic [LEVEL_W-1:0] level_o,
    input logic               borrow_o
);
    // R3
    toggle_on_borrow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        borrow_o |-> (tone_o != $past(tone_o)));

    // R3
    hold_without_borrow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !borrow_o |-> $stable(tone_o));

    // R4
    borrow_after_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        borrow_o |-> $past(tick_i));

    // R8
    silent_when_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tone_o |-> (level_o == '0));

    // R7
    off_code_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(atten_i) == {ATTEN_W{1'b1}}) |-> (level_o == '0));

    // R10
    no_tick_no_borrow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(tick_i) |-> !borrow_o);
endmodule

bind tone_channel tone_channel_chk #(.ATTEN_W(ATTEN_W), .LEVEL_W(LEVEL_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick_i   (tick_i),
    .atten_i  (atten_i),
    .tone_o   (tone_o),
    .level_o  (level_o),
    .borrow_o (borrow_o)
);

// File: tb/tb_tone_channel.sv
// Bench: directed scenarios for tone_channel, one task each.
module tb_tone_channel;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_i = 1'b0;
    logic [9:0] period_i = 10'd5;
    logic [3:0] atten_i = 4'd0;
    logic       tone_o;
    logic [3:0] level_o;
    logic       borrow_o;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    logic tick_run = 1'b0;
    int div = 0;

    tone_channel dut (
        .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .period_i(period_i),
        .atten_i(atten_i), .tone_o(tone_o), .level_o(level_o), .borrow_o(borrow_o)
    );

    always #10 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    // Tick source: one pulse every 16 clocks while enabled.
    always @(negedge clk) begin
        div <= (div == 15) ? 0 : div + 1;
        tick_i <= tick_run && (div == 15);
    end

    function automatic int exp_level(input int code);
        int t[16] = '{15, 12, 9, 8, 6, 5, 4, 3, 2, 2, 2, 1, 1, 1, 1, 0};
        return t[code];
    endfunction

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Waits at falling edges for the next borrow strobe; returns its cycle stamp.
    task automatic next_borrow(output int stamp);
        int n = 0;
        stamp = -1;
        while (n < 20000) begin
            @(negedge clk);
            if (borrow_o) begin
                stamp = cyc;
                break;
            end
            n++;
        end
        if (stamp < 0) check("timeout", 0, 1);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check("R1 tone", int'(tone_o), 0);
        check("R1 borrow", int'(borrow_o), 0);
        check("R1 level", int'(level_o), 0);
    endtask

    task automatic t_interval();
        int s0, s1, s2;
        logic t_prev;
        period_i = 10'd5;
        atten_i = 4'd0;
        @(negedge clk);
        rst_n = 1'b1;
        tick_run = 1'b1;
        next_borrow(s0);
        t_prev = tone_o;
        @(negedge clk);
        check("R4 strobe width", int'(borrow_o), 0);
        next_borrow(s1);
        check("R2 interval P=5", s1 - s0, 80);
        check("R3 toggle", int'(tone_o), int'(!t_prev));
        if (tone_o) check("R7 code0 level", int'(level_o), 15);
        else        check("R8 low silent", int'(level_o), 0);
        next_borrow(s2);
        check("R2 second interval", s2 - s1, 80);
        if (tone_o) check("R7 code0 level", int'(level_o), 15);
        else        check("R8 low silent", int'(level_o), 0);
    endtask

    task automatic t_atten_sweep();
        int s;
        logic held;
        next_borrow(s);
        if (!tone_o) next_borrow(s);
        @(posedge clk);
        #1 tick_run = 1'b0;
        held = tone_o;
        for (int c = 0; c < 16; c++) begin
            @(negedge clk);
            atten_i = 4'(c);
            @(negedge clk);
            check($sformatf("R7 R9 code %0d", c), int'(level_o), exp_level(c));
        end
        @(negedge clk);
        atten_i = 4'd3;
        check("R9 one clock delay", int'(level_o), 0);
        @(negedge clk);
        check("R9 updated", int'(level_o), 8);
        for (int k = 0; k < 100; k++) begin
            @(negedge clk);
            if (borrow_o || tone_o != held) check("R10 hold", 1, 0);
        end
        check("R10 tone held", int'(tone_o), int'(held));
        atten_i = 4'd0;
        tick_run = 1'b1;
    endtask

    task automatic t_period_change();
        int s0, s1, s2, s3;
        period_i = 10'd10;
        next_borrow(s0);
        next_borrow(s0);
        period_i = 10'd3;
        next_borrow(s1);
        check("R6 old half-period completes", s1 - s0, 160);
        next_borrow(s2);
        check("R6 new period", s2 - s1, 48);
        while (cyc < s2 + 47) @(negedge clk);
        period_i = 10'd7;
        next_borrow(s3);
        check("R6 edge-time reload stamp", s3 - s2, 48);
        next_borrow(s1);
        check("R6 value at reload edge taken", s1 - s3, 112);
    endtask

    task automatic t_period_zero();
        int s0, s1, s2;
        period_i = 10'd0;
        next_borrow(s0);
        next_borrow(s1);
        next_borrow(s2);
        check("R5 zero means 1024", s2 - s1, 16384);
    endtask

    task automatic t_reset_mid();
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 mid-run tone", int'(tone_o), 0);
        check("R1 mid-run level", int'(level_o), 0);
        check("R1 mid-run borrow", int'(borrow_o), 0);
        rst_n = 1'b1;
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        t_reset();
        t_interval();
        t_atten_sweep();
        t_period_change();
        t_period_zero();
        t_reset_mid();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule